// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that the fetch stage consults with the current fetch address. It returns the address to fetch next before the instruction has been decoded. An entry is kept only for branches that have been seen taken. Each entry holds three things: the branch's own address as a tag, the target it jumped to last, and a 2-bit saturating confidence counter. A lookup uses a stored target only when the full address matches and the counter leans towards taken. In every other case the next fetch address is the sequential one, the fetch address plus 4.

A single write port accepts resolved branches from later in the pipeline. A resolved taken branch that is not in the buffer claims the slot its address maps to, and any earlier occupant of that slot is discarded. A resolved branch that is already present moves its counter one step towards its outcome. A not-taken branch that is absent is dropped. Lookup is purely combinational. The write port acts on the rising clock edge, so a lookup in the same cycle as an update still sees the old contents.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous active-high reset every slot is empty, so every lookup reports pred_hit=0, pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R2: A lookup that finds no matching entry reports pred_hit=0, pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R3: There are 16 slots, selected by address bits [5:2]. Address bits [31:6] are stored as the tag and compared exactly, and bits [1:0] are ignored. An address that shares a slot with a stored branch but differs in any tag bit misses.
- R4: A resolved taken branch (upd_valid=1, upd_taken=1) whose address misses fills its slot with the tag, target = upd_target and counter = 3. From the next cycle, a lookup of that address reports hit, taken and the new target.
- R5: A resolved not-taken branch whose address misses changes nothing, so a later lookup of that address still misses.
- R6: Counter encoding: 0 and 1 predict not taken, and 2 and 3 predict taken. A hit whose counter is 0 or 1 reports pred_hit=1, pred_taken=0 and pred_next_pc = fetch_pc + 4, and the entry stays.
- R7: An update that hits adds 1 to the counter when taken and subtracts 1 when not taken. The counter saturates at 3 and at 0.
- R8: An entry whose counter is 3 still predicts taken after one not-taken update.
- R9: A taken update that hits replaces the stored target with upd_target. A not-taken update that hits leaves the target unchanged.
- R10: Filling a slot overwrites any different branch held there, which misses from then on.
- R11: Updates take effect at the clock edge. A lookup in the same cycle as an update sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | A slot holds this exact address |
| pred_taken | output | 1 | Hit and the counter predicts taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The bench aims at addresses that alias into the same slot with different tags. A design that compared only part of the address would hand out another branch's target, and one that failed to overwrite would keep returning the stale branch. The bench walks the counter to both ends and beyond them. A wrapping counter would turn strong not-taken into strong taken, and a buffer without hysteresis would stop predicting taken after a single loop exit. The bench also issues lookups in the same cycle as updates to the same address, which catches a write that is forwarded early. Not-taken misses are checked to confirm they leave no entry behind.

// File: rtl/btb_pkg.sv
package btb_pkg;

    parameter int ADDR_W  = 32;
    parameter int IDX_W   = 4;
    parameter int OFF_W   = 2;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(4);

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        ctr_e              ctr;
    } slot_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        slot_t            data;
    } slot_wr_t;

    function automatic logic [IDX_W-1:0] pc_index(input logic [ADDR_W-1:0] pc);
        return pc[OFF_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] pc_tag(input logic [ADDR_W-1:0] pc);
        return pc[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return (c == CTR_WEAK_T) || (c == CTR_STRONG_T);
    endfunction

    function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
        ctr_e r;
        r = c;
        if (taken) begin
            if (c != CTR_STRONG_T) r = ctr_e'(c + 2'd1);
        end else begin
            if (c != CTR_STRONG_NT) r = ctr_e'(c - 2'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output slot_t            rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output slot_t            rd_b,
    input  slot_wr_t         wr
);

    slot_t slots [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[e].vld <= 1'b0;
            end else if (wr.en && (wr.idx == IDX_W'(e))) begin
                slots[e] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_a = slots[rd_a_idx];
        rd_b = slots[rd_b_idx];
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  logic [ADDR_W-1:0] fetch_pc,
    input  slot_t             slot,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    logic [ADDR_W-1:0] seq_pc;

    always_comb begin
        seq_pc  = fetch_pc + SEQ_STEP;
        hit     = slot.vld && (slot.tag == pc_tag(fetch_pc));
        taken   = hit && ctr_says_taken(slot.ctr);
        next_pc = taken ? slot.tgt : seq_pc;
    end

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
(
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  slot_t             cur,
    output logic              upd_hit,
    output slot_wr_t          wr
);

    always_comb begin
        upd_hit      = cur.vld && (cur.tag == pc_tag(upd_pc));
        wr.en        = 1'b0;
        wr.idx       = pc_index(upd_pc);
        wr.data.vld  = 1'b1;
        wr.data.tag  = pc_tag(upd_pc);
        wr.data.tgt  = upd_target;
        wr.data.ctr  = CTR_STRONG_T;
        if (upd_valid) begin
            if (upd_hit) begin
                wr.en       = 1'b1;
                wr.data.ctr = ctr_step(cur.ctr, upd_taken);
                wr.data.tgt = upd_taken ? upd_target : cur.tgt;
            end else if (upd_taken) begin
                wr.en       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    slot_t    fetch_slot;
    slot_t    upd_slot;
    slot_wr_t wr_req;
    logic     upd_hit_w;
    ctr_e     upd_rd_ctr;

    assign upd_rd_ctr = upd_slot.ctr;

    btb_store i_store (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (pc_index(fetch_pc)),
        .rd_a     (fetch_slot),
        .rd_b_idx (pc_index(upd_pc)),
        .rd_b     (upd_slot),
        .wr       (wr_req)
    );

    btb_lookup i_lookup (
        .fetch_pc (fetch_pc),
        .slot     (fetch_slot),
        .hit      (pred_hit),
        .taken    (pred_taken),
        .next_pc  (pred_next_pc)
    );

    btb_update i_update (
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target),
        .cur        (upd_slot),
        .upd_hit    (upd_hit_w),
        .wr         (wr_req)
    );

endmodule

// File: rtl/btb_checker.sv
module btb_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        pred_hit,
    input logic        pred_taken,
    input logic [31:0] pred_next_pc,
    input logic        upd_valid,
    input logic [31:0] upd_pc,
    input logic        upd_taken,
    input logic [31:0] upd_target,
    input logic        upd_hit,
    input logic [1:0]  upd_ctr
);

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b1) |-> !pred_hit);

    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);

    a_r4_fill_visible: assert property (@(posedge clk) disable iff (rst)
        (($past(rst) == 1'b0) && $past(upd_valid) && $past(upd_taken) && !$past(upd_hit)
         && (fetch_pc == $past(upd_pc)))
        |-> (pred_hit && pred_taken && (pred_next_pc == $past(upd_target))));

    a_r5_nt_miss_no_fill: assert property (@(posedge clk) disable iff (rst)
        (($past(rst) == 1'b0) && $past(upd_valid) && !$past(upd_taken) && !$past(upd_hit)
         && (fetch_pc == $past(upd_pc)))
        |-> !pred_hit);

    a_r6_weak_hit_sequential: assert property (@(posedge clk) disable iff (rst)
        (pred_hit && !pred_taken) |-> (pred_next_pc == fetch_pc + 32'd4));

    a_r8_hysteresis: assert property (@(posedge clk) disable iff (rst)
        (($past(rst) == 1'b0) && $past(upd_valid) && !$past(upd_taken) && $past(upd_hit)
         && ($past(upd_ctr) == 2'd3) && (fetch_pc == $past(upd_pc)))
        |-> pred_taken);

endmodule

bind btb_predictor btb_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .upd_hit      (upd_hit_w),
    .upd_ctr      (upd_rd_ctr)
);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // behavioural model: one record per slot
    bit          m_vld [16];
    logic [31:0] m_pc  [16];
    logic [31:0] m_tgt [16];
    int          m_ctr [16];

    always #2 clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    function automatic bit model_match(input logic [31:0] pc);
        int s = int'(pc[5:2]);
        return m_vld[s] && (m_pc[s][31:2] == pc[31:2]);
    endfunction

    task automatic check_now(input string req);
        int s = int'(fetch_pc[5:2]);
        bit e_hit = model_match(fetch_pc);
        bit e_tk  = e_hit && (m_ctr[s] >= 2);
        logic [31:0] e_nx = e_tk ? m_tgt[s] : fetch_pc + 32'd4;
        total++;
        if (pred_hit !== e_hit || pred_taken !== e_tk || pred_next_pc !== e_nx) begin
            bad++;
            $display("FAIL %s pc=%h actual hit=%b tk=%b nx=%h expected hit=%b tk=%b nx=%h",
                     req, fetch_pc, pred_hit, pred_taken, pred_next_pc, e_hit, e_tk, e_nx);
        end
    endtask

    task automatic model_update();
        int s = int'(upd_pc[5:2]);
        if (!upd_valid) return;
        if (model_match(upd_pc)) begin
            if (upd_taken) begin
                if (m_ctr[s] < 3) m_ctr[s]++;
                m_tgt[s] = upd_target;
            end else if (m_ctr[s] > 0) begin
                m_ctr[s]--;
            end
        end else if (upd_taken) begin
            m_vld[s] = 1'b1;
            m_pc[s]  = upd_pc;
            m_tgt[s] = upd_target;
            m_ctr[s] = 3;
        end
    endtask

    // one cycle: drive, compare before the edge, then advance the model
    task automatic step(input string req, input logic [31:0] fpc, input logic uv,
                        input logic [31:0] upc, input logic ut, input logic [31:0] utgt);
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        #1;
        check_now(req);
        @(posedge clk);
        model_update();
    endtask

    task automatic look(input string req, input logic [31:0] fpc);
        step(req, fpc, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic upd(input string req, input logic [31:0] p, input logic t, input logic [31:0] g);
        step(req, p, 1'b1, p, t, g);
    endtask

    localparam logic [31:0] PA = 32'h0000_1008;
    localparam logic [31:0] PB = 32'h0000_1048; // same slot as PA, different tag

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: empty after reset
        look("R1", PA);
        look("R1", 32'hFFFF_FFFC);
        // R2: misses give sequential address
        look("R2", 32'h0000_0000);
        look("R2", 32'h1234_5670);
        // R5: not-taken miss leaves nothing
        upd("R5", PA, 1'b0, 32'h0000_2000);
        look("R5", PA);
        // R4 and R11: fill, invisible in the same cycle, visible next
        upd("R11", PA, 1'b1, 32'h0000_2000);
        look("R4", PA);
        // R8: one not-taken from strong taken still predicts taken
        upd("R8", PA, 1'b0, 32'h0);
        look("R8", PA);
        // R6: second not-taken, hit but sequential
        upd("R6", PA, 1'b0, 32'h0);
        look("R6", PA);
        // R7: walk to 0 and past it, then up to 3 and past it
        upd("R7", PA, 1'b0, 32'h0);
        upd("R7", PA, 1'b0, 32'h0);
        look("R7", PA);
        upd("R7", PA, 1'b1, 32'h0000_2000);
        look("R7", PA);
        upd("R7", PA, 1'b1, 32'h0000_2000);
        upd("R7", PA, 1'b1, 32'h0000_2000);
        upd("R7", PA, 1'b1, 32'h0000_2000);
        upd("R7", PA, 1'b0, 32'h0);
        look("R7", PA);
        // R9: taken hit refreshes target, not-taken hit keeps it
        upd("R9", PA, 1'b1, 32'h0000_3000);
        look("R9", PA);
        upd("R9", PA, 1'b0, 32'h0000_7777);
        look("R9", PA);
        // R3: alias with different tag misses
        look("R3", PB);
        look("R3", PA ^ 32'h8000_0000);
        // R10: fill of alias evicts PA
        upd("R10", PB, 1'b1, 32'h0000_4000);
        look("R10", PA);
        look("R10", PB);
        // R7: mixed traffic over aliasing addresses
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a = 32'h0000_1000 + ($urandom_range(0, 2) << 6) + ($urandom_range(0, 3) << 2);
            logic [31:0] b = 32'h0000_1000 + ($urandom_range(0, 2) << 6) + ($urandom_range(0, 3) << 2);
            step("R7", a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)), $urandom & 32'hFFFF_FFFC);
        end
        // R1: reset again empties everything
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        @(negedge clk) rst = 1'b0;
        look("R1", PB);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule